// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block sits on the host side of a Clause 22 management bus and lets a user reach 32-bit registers that live behind a paged, half-word-wide window. A request carries a short register offset, an operation code and, for writes, a data word and a mask. The bridge adds a fixed base to the offset and splits the resulting 24-bit address into three parts: a page number, a three-bit suffix for the PHY address, and a register index. It then generates MDC itself and shifts out the management frames on MDIO.

Every access opens with a page-select write to a fixed register of a fixed PHY address. Then come two 16-bit data frames: the low half-word first, then the high half-word. The high half-word is reached by setting bit 1 of the register field. A read-modify-write reads both halves, merges in the new value and writes both halves back. It does all of this as one sequence, and the bridge accepts no other request until that sequence is over. If the target device fails to answer a read, the rest of the sequence is dropped and the response carries an error flag.

Top module: `mdio_paged_bridge`

## Requirements
- R1: `req_ready` is high only when the bridge is idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response, which is a single-cycle `rsp_valid` pulse. Operation codes: 00 read, 01 write, 10 read-modify-write, 11 read.
- R2: The full address is `BASE_ADDR + req_off`, taken modulo 2^24. The first frame of every access is a write of address bits [23:8] to register `PAGE_REG` at PHY address `HIGH_PHY`.
- R3: Every data frame uses the PHY address `LOW_PFX` ORed with address bits [7:5]. The register field carries address bits [4:2] in bit positions 4:2 and zero in bits 1:0 for the low half-word. The high half-word uses the same value with bit 1 set.
- R4: The frames of an access follow a fixed order. A read is page, read-low, read-high (3 frames). A write is page, write-low (`req_wdata[15:0]`), write-high (`req_wdata[31:16]`) (3 frames).
- R5: A read returns the low half-word in `rsp_rdata[15:0]` and the high half-word in `rsp_rdata[31:16]`.
- R6: A read-modify-write issues five frames in this order: page, read-low, read-high, write-low, write-high. The value written is `(old & ~req_mask) | req_wdata`, so `req_wdata` bits outside the mask are still ORed in. `rsp_rdata` returns the old word.
- R7: Each frame is 64 MDC bits, most significant bit first: 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register, turnaround, and 16 data bits. On a write the turnaround is driven as 1 then 0.
- R8: MDC has a period of `2*CLK_DIV` clocks while frames run and is low whenever the bridge is idle. `mdio_o` and `mdio_oe` change only while MDC is low. When idle, `mdio_oe` is 0.
- R9: During a read frame, `mdio_oe` drops to 0 from the first turnaround bit to the end of the frame. Read data is sampled at the rising edge of MDC.
- R10: On a read frame, if MDIO is high at the second turnaround bit, the bridge flags `rsp_err`. It issues no further MDC edges for that access, and a read-modify-write then writes nothing. A plain write never flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request can be taken |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 read-modify-write, 11 read |
| req_off | input | OFF_W | Register offset added to the base |
| req_wdata | input | 32 | Write data or value to OR in |
| req_mask | input | 32 | Bits cleared before the OR on read-modify-write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Device did not answer a read frame |
| rsp_rdata | output | 32 | Word read (old word for read-modify-write) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the bridge |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO bus value |

## Verification
The hardest case to reach is a failure in the middle of a sequence. In a read-modify-write, the low half-word read succeeds and only the high read goes unanswered. The write-back must then never appear on the bus. The bench device model has a switch that keeps it silent only for register fields with bit 1 set. Turning that switch on during a read-modify-write produces exactly this case. The bench then checks that only the page and read-low frames were logged. A later clean read of the same word must return the value from before the failed access.

// File: rtl/mdio_paged_bridge.sv
`timescale 1ns/1ps
module mdio_paged_bridge #(
  parameter int          CLK_DIV   = 4,
  parameter int          OFF_W     = 12,
  parameter logic [23:0] BASE_ADDR = 24'h12_3400,
  parameter logic [4:0]  LOW_PFX   = 5'h10,
  parameter logic [4:0]  HIGH_PHY  = 5'h18,
  parameter logic [4:0]  PAGE_REG  = 5'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [OFF_W-1:0] req_off,
  input  logic [31:0]      req_wdata,
  input  logic [31:0]      req_mask,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int PH_W = $clog2(2 * CLK_DIV);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(CLK_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * CLK_DIV - 1);
  localparam logic [1:0] OPC_WR = 2'b01;
  localparam logic [1:0] OPC_RD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t          st;
  logic [1:0]      op_q;
  logic [2:0]      step;
  logic [PH_W-1:0] ph;
  logic [5:0]      bi;
  logic [63:0]     frm;
  logic            rd_frm;
  logic [15:0]     sh;
  logic [31:0]     rdata;
  logic            err;
  logic [2:0]      reg_idx, phy_lo;
  logic [31:0]     wd_q, mk_q;

  logic [21:0] full_w;
  logic        is_wr, is_rmw, n_hi, n_rd;
  logic [2:0]  nstep, last_step;
  logic [31:0] wr_word;
  logic [63:0] n_frm;

  function automatic logic [63:0] mk_frame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? OPC_RD : OPC_WR, phy, rg, 2'b10, d};
  endfunction

  assign full_w    = 22'((BASE_ADDR + 24'(req_off)) >> 2);
  assign is_wr     = op_q == 2'b01;
  assign is_rmw    = op_q == 2'b10;
  assign last_step = is_rmw ? 3'd4 : 3'd2;
  assign nstep     = step + 3'd1;
  assign n_hi      = (nstep == 3'd2) || (nstep == 3'd4);
  assign n_rd      = !is_wr && (nstep <= 3'd2);
  assign wr_word   = is_wr ? wd_q : ((rdata & ~mk_q) | wd_q);
  assign n_frm     = mk_frame(n_rd, LOW_PFX | {2'b00, phy_lo}, {reg_idx, n_hi, 1'b0},
                              n_rd ? 16'h0000 : (n_hi ? wr_word[31:16] : wr_word[15:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; step <= '0; ph <= '0; bi <= '0; frm <= '0;
      rd_frm <= 1'b0; sh <= '0; rdata <= '0; err <= 1'b0;
      reg_idx <= '0; phy_lo <= '0; wd_q <= '0; mk_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          wd_q    <= req_wdata;
          mk_q    <= req_mask;
          reg_idx <= full_w[2:0];
          phy_lo  <= full_w[5:3];
          frm     <= mk_frame(1'b0, HIGH_PHY, PAGE_REG, full_w[21:6]);
          rd_frm  <= 1'b0;
          step    <= '0;
          ph      <= '0;
          bi      <= '0;
          err     <= 1'b0;
          rdata   <= '0;
          st      <= S_RUN;
        end
        S_RUN: begin
          ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
          if (ph == PH_RISE && rd_frm) begin
            if (bi == 6'd47 && mdio_i) begin
              err <= 1'b1;
              st  <= S_DONE;
            end
            if (bi >= 6'd48) sh <= {sh[14:0], mdio_i};
          end
          if (ph == PH_LAST) begin
            if (bi == 6'd63) begin
              if (rd_frm) begin
                if (step == 3'd2) rdata[31:16] <= sh;
                else              rdata[15:0]  <= sh;
              end
              if (step == last_step) st <= S_DONE;
              else begin
                step   <= nstep;
                frm    <= n_frm;
                rd_frm <= n_rd;
                bi     <= '0;
              end
            end else begin
              bi  <= bi + 6'd1;
              frm <= {frm[62:0], 1'b0};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign rsp_valid = st == S_DONE;
  assign rsp_err   = err;
  assign rsp_rdata = rdata;
  assign mdc       = (st == S_RUN) && (ph >= PH_HIGH);
  assign mdio_o    = frm[63];
  assign mdio_oe   = (st == S_RUN) && !(rd_frm && bi >= 6'd46);

  p_accept_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_mdio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && !mdio_oe));
  p_write_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == 2'b01) |-> !rsp_err);
  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (step <= last_step));
endmodule

// File: tb/mdio_paged_bridge_tb_top.sv
`timescale 1ns/1ps
module mdio_paged_bridge_tb_top;
  localparam int          DIV   = 2;
  localparam logic [23:0] BASE  = 24'h12_3400;
  localparam logic [4:0]  LOWP  = 5'h10;
  localparam logic [4:0]  HIGHP = 5'h18;
  localparam logic [4:0]  PREG  = 5'h00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [11:0] req_off = '0;
  logic [31:0] req_wdata = '0, req_mask = '0;
  logic rsp_valid, rsp_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [31:0] rsp_rdata;
  logic phy_oe = 1'b0, phy_o = 1'b1;

  always #5 clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_paged_bridge #(.CLK_DIV(DIV), .OFF_W(12), .BASE_ADDR(BASE), .LOW_PFX(LOWP),
                      .HIGH_PHY(HIGHP), .PAGE_REG(PREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_off(req_off), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic int key_of(logic [15:0] pg, logic [4:0] phy, logic [4:0] rg);
    return int'({pg, phy, rg});
  endfunction
  function automatic logic [15:0] dflt(int k);
    return 16'(k) ^ 16'h5A5A;
  endfunction

  // device model and per-clock comparison (single owner of its state)
  bit mute_all = 0, mute_hi = 0;
  logic [27:0] log_q[$];
  logic [15:0] mem[int];
  int pc_n = 0, pc_f = 0, bn = 0, cyc = 0, last_r = 0;
  bit have_rise = 0;
  logic mdc_p = 0, o_p = 0, oe_p = 0;
  logic [1:0] d_op = '0;
  logic [4:0] d_phy = '0, d_reg = '0;
  logic [15:0] d_data = '0, cur_page = '0, rdv = '0;

  task automatic pc(bit ok, string r, int a, int e);
    pc_n++;
    if (!ok) begin pc_f++; $display("FAIL %s actual=%0h expected=%0h", r, a, e); end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bn = 0; have_rise = 0; phy_oe <= 1'b0; mdc_p = 0;
    end else begin
      if (req_ready) pc(!mdc && !mdio_oe, "R8 idle", {mdc, mdio_oe}, 0);
      if (mdc && mdc_p) pc(mdio_o == o_p && mdio_oe == oe_p, "R8 hold", {mdio_o, mdio_oe}, {o_p, oe_p});
      if (!req_ready && d_op == 2'b10 && (bn > 46 || (bn == 46 && !mdc)))
        pc(!mdio_oe, "R9 release", mdio_oe, 0);
      if (mdc && !mdc_p) begin
        logic b;
        b = mdio_i;
        if (have_rise) pc(cyc - last_r == 2 * DIV, "R8 period", cyc - last_r, 2 * DIV);
        have_rise = 1; last_r = cyc;
        if (bn < 32) pc(b == 1'b1, "R7 preamble", b, 1);
        else if (bn < 34) pc(b == (bn == 33), "R7 start", b, int'(bn == 33));
        else if (bn < 36) d_op = {d_op[0], b};
        else if (bn < 41) d_phy = {d_phy[3:0], b};
        else if (bn < 46) d_reg = {d_reg[3:0], b};
        else if (bn < 48) begin
          if (d_op == 2'b01) pc(b == (bn == 46), "R7 turnaround", b, int'(bn == 46));
        end else d_data = {d_data[14:0], b};
        if (d_op == 2'b10) begin
          if (bn == 45) begin
            int k;
            k = key_of(cur_page, d_phy, d_reg);
            rdv = mem.exists(k) ? mem[k] : dflt(k);
          end
          if (bn == 46 && !(mute_all || (mute_hi && d_reg[1]))) begin
            phy_oe <= 1'b1; phy_o <= 1'b0;
          end
          if (bn >= 47 && bn <= 62) phy_o <= rdv[62 - bn];
          if (bn == 63) phy_oe <= 1'b0;
        end
        if (bn == 63) begin
          if (d_op == 2'b01) begin
            if (d_phy == HIGHP && d_reg == PREG) cur_page = d_data;
            else mem[key_of(cur_page, d_phy, d_reg)] = d_data;
          end
          log_q.push_back({d_op, d_phy, d_reg, d_data});
          bn = 0;
        end else bn++;
      end
      if (rsp_valid) begin bn = 0; have_rise = 0; phy_oe <= 1'b0; end
      mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
    end
  end

  // stimulus and request-level reference
  int n_chk = 0, n_fail = 0;
  logic [15:0] ref_mem[int];
  bit wd_hit = 0;

  task automatic chk(bit ok, string r, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", r, a, e); end
  endtask

  function automatic logic [15:0] ref_get(int k);
    return ref_mem.exists(k) ? ref_mem[k] : dflt(k);
  endfunction

  task automatic run(input logic [1:0] op, input logic [11:0] off, input logic [31:0] wd,
                     input logic [31:0] mk, input int cut, input bit exp_err);
    logic [23:0] a;
    logic [15:0] pg, lo, hi;
    logic [4:0] phy, rg, rgh;
    logic [31:0] exp_rd, nw, got;
    logic [27:0] eq[$];
    int klo, khi, base;
    logic e;
    string tag;
    a = BASE + 24'(off);
    pg = a[23:8]; phy = LOWP | {2'b00, a[7:5]};
    rg = {a[4:2], 2'b00}; rgh = rg | 5'h02;
    klo = key_of(pg, phy, rg); khi = key_of(pg, phy, rgh);
    eq.push_back({2'b01, HIGHP, PREG, pg});
    exp_rd = '0; nw = wd;
    if (op == 2'b01) begin
      eq.push_back({2'b01, phy, rg, wd[15:0]});
      eq.push_back({2'b01, phy, rgh, wd[31:16]});
      tag = "R4 write";
    end else begin
      lo = ref_get(klo); hi = ref_get(khi);
      exp_rd = {hi, lo};
      eq.push_back({2'b10, phy, rg, lo});
      eq.push_back({2'b10, phy, rgh, hi});
      tag = "R3 read";
      if (op == 2'b10) begin
        nw = (exp_rd & ~mk) | wd;
        eq.push_back({2'b01, phy, rg, nw[15:0]});
        eq.push_back({2'b01, phy, rgh, nw[31:16]});
        tag = "R6 rmw";
      end
    end
    while (cut >= 0 && eq.size() > cut) void'(eq.pop_back());
    if (!exp_err && op != 2'b00 && op != 2'b11) begin
      ref_mem[klo] = nw[15:0]; ref_mem[khi] = nw[31:16];
    end
    base = log_q.size();
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_off = off; req_wdata = wd; req_mask = mk;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 busy", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    got = rsp_rdata; e = rsp_err;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 single pulse", {rsp_valid, req_ready}, 32'h1);
    chk(e == exp_err, "R10 error flag", e, exp_err);
    if (op != 2'b01 && !exp_err)
      chk(got == exp_rd, op == 2'b10 ? "R6 old word" : "R5 read word", got, exp_rd);
    chk(log_q.size() - base == eq.size(), "R4 frame count", log_q.size() - base, eq.size());
    for (int i = 0; i < eq.size() && base + i < log_q.size(); i++)
      chk(log_q[base + i] == eq[i], i == 0 ? "R2 page frame" : tag, log_q[base + i], eq[i]);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 reset ready", req_ready, 1);
        chk(!rsp_valid, "R1 reset rsp", rsp_valid, 0);
        chk(!mdc && !mdio_oe, "R8 reset bus", {mdc, mdio_oe}, 0);
        run(2'b01, 12'h000, 32'h1234_5678, 32'h0, -1, 0);
        run(2'b00, 12'h000, 32'h0, 32'h0, -1, 0);
        run(2'b01, 12'h0FC, 32'hCAFE_F00D, 32'h0, -1, 0);
        run(2'b00, 12'h0FC, 32'h0, 32'h0, -1, 0);
        run(2'b00, 12'h048, 32'h0, 32'h0, -1, 0);
        run(2'b11, 12'hF04, 32'h0, 32'h0, -1, 0);
        run(2'b10, 12'h000, 32'h0000_AB00, 32'h0000_FF00, -1, 0);
        run(2'b00, 12'h000, 32'h0, 32'h0, -1, 0);
        run(2'b10, 12'h0FC, 32'h0000_0001, 32'h0, -1, 0);
        run(2'b10, 12'hF20, 32'h8000_0000, 32'hFFFF_0000, -1, 0);
        mute_all = 1;
        run(2'b00, 12'h0FC, 32'h0, 32'h0, 1, 1);
        run(2'b01, 12'h010, 32'h0BAD_BEEF, 32'h0, -1, 0);
        mute_all = 0; mute_hi = 1;
        run(2'b10, 12'h000, 32'hFFFF_FFFF, 32'h0, 2, 1);
        mute_hi = 0;
        run(2'b00, 12'h000, 32'h0, 32'h0, -1, 0);
        run(2'b00, 12'h010, 32'h0, 32'h0, -1, 0);
      end
      begin
        #2_000_000;
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("%0d/%0d checks passed", (n_chk + pc_n) - (n_fail + pc_f), n_chk + pc_n);
    $finish;
  end
endmodule